// File: doc/BRIEF.md
# Receive Subaddress Descriptor Control Word

This block holds the control word of one receive-subaddress descriptor in a 1553 remote terminal and applies the access rules for each bit of it. A host reaches the word through a plain register port with a select, read and write strobes and a 16-bit data path. The terminal's message engine reaches it through a device update port, which writes the four device-maintained status bits. An execution-enable flag decides which of the two sides may change which bits.

Decoded command words come in as a transmit/receive flag and a subaddress. Only receive commands to subaddresses 1 through 30 open a message window. While that window is open, device updates are accepted and completion is recognised. On completion the block can raise an index-equals-zero interrupt as a single-cycle pulse. It fires in indexed-buffer mode when the message index runs out, and in circular-buffer mode when a preset message count has been reached.

Master reset clears everything. Soft reset clears only the three activity flags. A host read clears the data-block-accessed flag once the read data has been captured.

Top module: `rt_rx_desc_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the control word, `host_rdata` and `irq` all become zero.
- R2: A read (`host_sel` and `host_rd` high) loads `host_rdata` at that edge with the word's value before the edge. A read with `host_sel` low changes neither `host_rdata` nor the word.
- R3: A host write (`host_sel` and `host_wr` high) always updates bits 15:12 and bit 3 from `host_wdata`.
- R4: A host write updates bits 7:4 and 2:0 only while `exec_en` is 0. While `exec_en` is 1 those bits keep their value.
- R5: Bits 11:8 are never changed by a host write.
- R6: A device update (`dev_upd` high) copies `dev_bits[3:0]` into word bits 11:8, with `dev_bits[3]` going to bit 11. It takes effect only while `exec_en` is 1 and a qualified message window is open. Otherwise it is ignored.
- R7: A `cmd_valid` pulse opens a message window only if `exec_en` is 1, `cmd_tr` is 0 (receive) and `cmd_sa` is between 1 and 30. Subaddresses 0 and 31 (mode codes) and transmit commands are ignored. A `cmd_done` pulse closes an open window. If a new qualifying command arrives in the same cycle, the window stays open.
- R8: A host read clears bit 11 (data-block-accessed) at the edge after the old value is captured. A device update setting bit 11 in the same cycle wins.
- R9: A `soft_rst` pulse clears bits 11, 10 and 9 and leaves every other bit unchanged.
- R10: In indexed mode (`circ_mode` = 0), a `cmd_done` that closes an open window with `idx_val` equal to 1 gives a one-cycle `irq` in the following cycle. A completion with `idx_val` equal to 0 gives none.
- R11: In circular mode (`circ_mode` = 1), completions of open windows are counted. The completion that brings the count to `circ_limit` pulses `irq` and restarts the count. A `circ_limit` of 0 never fires.
- R12: `irq` requires word bit 7 (interrupt enable) and `irq_glob_en` both high at the completing cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| soft_rst | input | 1 | Soft reset pulse, clears the activity flags |
| exec_en | input | 1 | Terminal execution enable |
| host_sel | input | 1 | Host address matches this word |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered host read data |
| cmd_valid | input | 1 | Decoded command word strobe |
| cmd_tr | input | 1 | Command transmit (1) / receive (0) flag |
| cmd_sa | input | 5 | Command subaddress |
| cmd_done | input | 1 | Command processing complete |
| dev_upd | input | 1 | Device status update strobe |
| dev_bits | input | 4 | Device status for word bits 11:8 |
| irq_glob_en | input | 1 | Global index-equals-zero interrupt enable |
| circ_mode | input | 1 | 0 indexed buffer, 1 circular buffer |
| idx_val | input | 8 | Message index before the current completion |
| circ_limit | input | 8 | Messages per circular round |
| irq | output | 1 | Index-equals-zero interrupt pulse |

## Verification
The assertions cover the rules that hold on every cycle. The device field is frozen while execution is off, and the host-idle bits are frozen while it is on. Soft reset and an undisturbed read leave the activity flags clear. Read data equals the word's previous value. Every interrupt is traced back to a completion with both enables high, and mode-code and transmit commands never open a window. Only the bench scenarios show the write permissions and the device-wins collision as concrete word values, along with the decrement-to-zero and circular-count interrupt timing and the master reset in the middle of a run.

// File: rtl/rt_desc_pkg.sv
package rt_desc_pkg;
  localparam int WORD_W    = 16;
  localparam int SA_W      = 5;
  localparam int DEV_LSB   = 8;
  localparam int DEV_W     = 4;
  localparam int BIT_DBAC  = 11;
  localparam int BIT_DPB   = 10;
  localparam int BIT_BCAST = 9;
  localparam int BIT_IXZEN = 7;

  typedef logic [WORD_W-1:0] cword_t;

  // writable by the host in any state
  localparam cword_t MASK_ANYTIME = 16'hF008;
  // writable by the host only while execution is disabled
  localparam cword_t MASK_IDLE    = 16'h00F7;
  // cleared by soft reset
  localparam cword_t MASK_SRST    = cword_t'((1 << BIT_DBAC) | (1 << BIT_DPB) | (1 << BIT_BCAST));
endpackage

// File: rtl/rt_cmd_qual.sv
module rt_cmd_qual #(
  parameter int SA_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            exec_en,
  input  logic            cmd_valid,
  input  logic            cmd_tr,
  input  logic [SA_W-1:0] cmd_sa,
  input  logic            cmd_done,
  output logic            active,
  output logic            done_ok
);
  localparam logic [SA_W-1:0] SA_LOW_MC  = '0;
  localparam logic [SA_W-1:0] SA_HIGH_MC = '1;

  logic qual;

  always_comb begin
    qual = exec_en && cmd_valid && !cmd_tr &&
           (cmd_sa != SA_LOW_MC) && (cmd_sa != SA_HIGH_MC);
  end

  always_ff @(posedge clk) begin
    if (rst)           active <= 1'b0;
    else if (qual)     active <= 1'b1;
    else if (cmd_done) active <= 1'b0;
  end

  assign done_ok = cmd_done && active;
endmodule

// File: rtl/rt_ctrl_word.sv
module rt_ctrl_word
  import rt_desc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             exec_en,
  input  logic             host_sel,
  input  logic             host_rd,
  input  logic             host_wr,
  input  cword_t           host_wdata,
  input  logic             dev_upd,
  input  logic             cmd_active,
  input  logic [DEV_W-1:0] dev_bits,
  output cword_t           word,
  output cword_t           rdata
);
  cword_t wmask;
  cword_t nxt;
  logic   rd_hit;
  logic   dev_hit;

  always_comb begin
    rd_hit  = host_sel && host_rd;
    dev_hit = dev_upd && exec_en && cmd_active;
    wmask   = MASK_ANYTIME | (exec_en ? '0 : MASK_IDLE);
    nxt     = word;
    if (host_sel && host_wr) nxt = (nxt & ~wmask) | (host_wdata & wmask);
    if (rd_hit)              nxt[BIT_DBAC] = 1'b0;
    if (dev_hit)             nxt[DEV_LSB +: DEV_W] = dev_bits;
    if (soft_rst)            nxt = nxt & ~MASK_SRST;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word  <= '0;
      rdata <= '0;
    end else begin
      word <= nxt;
      if (rd_hit) rdata <= word;
    end
  end
endmodule

// File: rtl/rt_ixz_irq.sv
module rt_ixz_irq #(
  parameter int IDX_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done_ok,
  input  logic             ixz_en,
  input  logic             glob_en,
  input  logic             circ_mode,
  input  logic [IDX_W-1:0] idx_val,
  input  logic [CNT_W-1:0] circ_limit,
  output logic             irq
);
  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;
  logic             hit_circ;
  logic             hit_idx;
  logic             fire;

  always_comb begin
    cnt_inc  = cnt + 1'b1;
    hit_circ = (circ_limit != CNT_ZERO) && (cnt_inc == circ_limit);
    hit_idx  = (idx_val == IDX_ONE);
    fire     = done_ok && ixz_en && glob_en && (circ_mode ? hit_circ : hit_idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      irq <= fire;
      if (done_ok && circ_mode) cnt <= hit_circ ? CNT_ZERO : cnt_inc;
    end
  end
endmodule

// File: rtl/rt_rx_desc_ctrl.sv
module rt_rx_desc_ctrl
  import rt_desc_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              exec_en,
  input  logic              host_sel,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              cmd_valid,
  input  logic              cmd_tr,
  input  logic [SA_W-1:0]   cmd_sa,
  input  logic              cmd_done,
  input  logic              dev_upd,
  input  logic [DEV_W-1:0]  dev_bits,
  input  logic              irq_glob_en,
  input  logic              circ_mode,
  input  logic [IDX_W-1:0]  idx_val,
  input  logic [CNT_W-1:0]  circ_limit,
  output logic              irq
);
  cword_t ctrl_q;
  logic   cmd_active;
  logic   done_ok;

  rt_cmd_qual #(.SA_W(SA_W)) u_qual (
    .clk(clk), .rst(rst), .exec_en(exec_en),
    .cmd_valid(cmd_valid), .cmd_tr(cmd_tr), .cmd_sa(cmd_sa),
    .cmd_done(cmd_done), .active(cmd_active), .done_ok(done_ok)
  );

  rt_ctrl_word u_word (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .exec_en(exec_en),
    .host_sel(host_sel), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .dev_upd(dev_upd), .cmd_active(cmd_active),
    .dev_bits(dev_bits), .word(ctrl_q), .rdata(host_rdata)
  );

  rt_ixz_irq #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_irq (
    .clk(clk), .rst(rst), .done_ok(done_ok), .ixz_en(ctrl_q[BIT_IXZEN]),
    .glob_en(irq_glob_en), .circ_mode(circ_mode), .idx_val(idx_val),
    .circ_limit(circ_limit), .irq(irq)
  );
endmodule

// File: rtl/rt_rx_desc_ctrl_chk.sv
module rt_rx_desc_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        soft_rst,
  input logic        exec_en,
  input logic        host_sel,
  input logic        host_rd,
  input logic        dev_upd,
  input logic        cmd_valid,
  input logic        cmd_tr,
  input logic [4:0]  cmd_sa,
  input logic        cmd_done,
  input logic        irq_glob_en,
  input logic        irq,
  input logic [15:0] host_rdata,
  input logic [15:0] word,
  input logic        active
);
  // R6
  dev_field_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!exec_en && !soft_rst) |=> $stable(word[10:8]));

  // R4
  idle_bits_locked_chk: assert property (@(posedge clk) disable iff (rst)
    exec_en |=> ($stable(word[7:4]) && $stable(word[2:0])));

  // R8
  read_clears_dbac_chk: assert property (@(posedge clk) disable iff (rst)
    (host_sel && host_rd && !dev_upd) |=> !word[11]);

  // R9
  soft_reset_flags_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (word[11:9] == 3'b000));

  // R2
  read_data_chk: assert property (@(posedge clk) disable iff (rst)
    (host_sel && host_rd) |=> (host_rdata == $past(word)));

  // R12
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(cmd_done) && $past(irq_glob_en) && $past(word[7])));

  // R7
  mode_code_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !active && !cmd_done && (cmd_tr || cmd_sa == 5'd0 || cmd_sa == 5'd31))
      |=> !active);
endmodule

bind rt_rx_desc_ctrl rt_rx_desc_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .exec_en(exec_en),
  .host_sel(host_sel), .host_rd(host_rd), .dev_upd(dev_upd),
  .cmd_valid(cmd_valid), .cmd_tr(cmd_tr), .cmd_sa(cmd_sa), .cmd_done(cmd_done),
  .irq_glob_en(irq_glob_en), .irq(irq), .host_rdata(host_rdata),
  .word(ctrl_q), .active(cmd_active)
);

// File: tb/rt_rx_desc_ctrl_tb.sv
`timescale 1ns/1ps
module rt_rx_desc_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1, soft_rst = 1'b0, exec_en = 1'b0;
  logic        host_sel = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        cmd_valid = 1'b0, cmd_tr = 1'b0, cmd_done = 1'b0;
  logic [4:0]  cmd_sa = '0;
  logic        dev_upd = 1'b0;
  logic [3:0]  dev_bits = '0;
  logic        irq_glob_en = 1'b0, circ_mode = 1'b0;
  logic [7:0]  idx_val = '0, circ_limit = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  // behavioural reference state
  int m_word = 0, m_rdata = 0, m_active = 0, m_cnt = 0, m_irq = 0;

  always #5 clk = ~clk;

  rt_rx_desc_ctrl u_dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .exec_en(exec_en),
    .host_sel(host_sel), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cmd_valid(cmd_valid), .cmd_tr(cmd_tr), .cmd_sa(cmd_sa), .cmd_done(cmd_done),
    .dev_upd(dev_upd), .dev_bits(dev_bits), .irq_glob_en(irq_glob_en),
    .circ_mode(circ_mode), .idx_val(idx_val), .circ_limit(circ_limit), .irq(irq)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    int nw, nr, na, nc, ni, open;
    bit qual, fire;
    if (rst) begin
      nw = 0; nr = 0; na = 0; nc = 0; ni = 0;
    end else begin
      nw = m_word; nr = m_rdata; na = m_active; nc = m_cnt;
      if (host_sel && host_wr) begin
        nw = (nw & ~'hF008) | (host_wdata & 'hF008);
        if (!exec_en) nw = (nw & ~'h00F7) | (host_wdata & 'h00F7);
      end
      if (host_sel && host_rd) begin
        nr = m_word;
        nw = nw & ~'h0800;
      end
      if (dev_upd && exec_en && m_active != 0) nw = (nw & ~'h0F00) | (int'(dev_bits) << 8);
      if (soft_rst) nw = nw & ~'h0E00;
      qual = exec_en && cmd_valid && !cmd_tr && cmd_sa >= 1 && cmd_sa <= 30;
      open = m_active;
      if (qual) na = 1; else if (cmd_done) na = 0;
      fire = 0;
      if (cmd_done && open != 0) begin
        if (circ_mode) begin
          if (circ_limit != 0 && ((m_cnt + 1) % 256) == circ_limit) begin
            fire = 1; nc = 0;
          end else nc = (m_cnt + 1) % 256;
        end else fire = (idx_val == 1);
        fire = fire && ((m_word >> 7) & 1) != 0 && irq_glob_en;
      end
      ni = fire;
    end
    @(posedge clk);
    #1;
    m_word = nw; m_rdata = nr; m_active = na; m_cnt = nc; m_irq = ni;
    if (!rst) begin
      chk("model rdata (R2)", host_rdata, m_rdata);
      chk("model irq (R10)", irq, m_irq);
    end
  endtask

  task automatic rd_check(input string tag, input int exp);
    host_sel = 1; host_rd = 1; tick(); host_sel = 0; host_rd = 0;
    chk(tag, host_rdata, exp);
  endtask

  task automatic wr(input logic [15:0] d);
    host_sel = 1; host_wr = 1; host_wdata = d; tick(); host_sel = 0; host_wr = 0;
  endtask

  task automatic send_cmd(input logic tr, input logic [4:0] sa);
    cmd_valid = 1; cmd_tr = tr; cmd_sa = sa; tick(); cmd_valid = 0;
  endtask

  task automatic dev(input logic [3:0] b);
    dev_upd = 1; dev_bits = b; tick(); dev_upd = 0;
  endtask

  task automatic done_check(input string tag, input logic [7:0] idx, input int exp);
    cmd_done = 1; idx_val = idx; tick(); cmd_done = 0;
    chk(tag, irq, exp);
    tick();
    chk({tag, " pulse ends"}, irq, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    #1;
    chk("R1 reset rdata", host_rdata, 0);
    chk("R1 reset irq", irq, 0);

    // R3 R4 R5: all bits writable except 11:8 while idle
    exec_en = 0; wr(16'hFFFF);
    rd_check("R5 idle write skips 11:8", 16'hF0FF);
    exec_en = 1; wr(16'h0000);
    rd_check("R3 R4 exec write", 16'h00F7);

    // R6: no window open
    dev(4'hF);
    rd_check("R6 update without window", 16'h00F7);

    // R7: mode codes and transmit ignored
    send_cmd(0, 5'd0); send_cmd(0, 5'd31); send_cmd(1, 5'd5);
    dev(4'hF);
    rd_check("R7 mode code/transmit ignored", 16'h00F7);

    // R7 R6: subaddress 30 receive qualifies
    send_cmd(0, 5'd30);
    dev(4'hF);
    host_rd = 1; host_sel = 0; tick(); host_rd = 0;
    chk("R2 unselected read", host_rdata, 16'h00F7);
    rd_check("R6 device update", 16'h0FF7);
    rd_check("R8 read cleared flag", 16'h07F7);

    // R9
    dev(4'hF);
    soft_rst = 1; tick(); soft_rst = 0;
    rd_check("R9 soft reset subset", 16'h01F7);

    // R8 collision: device set wins
    dev_upd = 1; dev_bits = 4'hF; host_sel = 1; host_rd = 1; tick();
    dev_upd = 0; host_sel = 0; host_rd = 0;
    chk("R8 collision read data", host_rdata, 16'h01F7);
    rd_check("R8 device set wins", 16'h0FF7);

    // R10 indexed mode
    irq_glob_en = 1; circ_mode = 0;
    done_check("R10 index 1 to 0", 8'd1, 1);
    send_cmd(0, 5'd1);
    done_check("R10 index stays 0", 8'd0, 0);

    // R12 enables
    exec_en = 0; wr(16'h0000); exec_en = 1;
    rd_check("R4 idle clear", 16'h0700);
    send_cmd(0, 5'd1);
    done_check("R12 word enable low", 8'd1, 0);
    exec_en = 0; wr(16'h0080); exec_en = 1;
    irq_glob_en = 0;
    send_cmd(0, 5'd1);
    done_check("R12 global enable low", 8'd1, 0);

    // R11 circular mode
    irq_glob_en = 1; circ_mode = 1; circ_limit = 8'd3;
    for (int k = 0; k < 6; k++) begin
      send_cmd(0, 5'd2);
      done_check("R11 circular count", 8'd0, (k % 3 == 2) ? 1 : 0);
    end
    circ_limit = 8'd0;
    for (int k = 0; k < 4; k++) begin
      send_cmd(0, 5'd2);
      done_check("R11 zero limit", 8'd0, 0);
    end

    // R1 master reset mid-run
    rst = 1; tick(); rst = 0;
    rd_check("R1 word cleared", 16'h0000);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule